// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration register space of a single bus function and answers configuration reads and writes of 1, 2 or 4 bytes. The access address is split into a bus number (bits 23:16), a device/function number (bits 15:8) and a byte offset (bits 7:0). Only the bus and device/function numbers set by parameter select this function. Any other target reads as all ones and ignores writes.

Each byte has write protection, and which bytes are protected depends on the header type parameter. Writes to the command and status bytes lose their reserved bits. A full-width write to a sized base address register or to the expansion ROM register is masked to the window size before it is stored. On a bridge header, writes to the secondary bus number byte are copied to a dedicated output. A one-cycle pulse tells the address decoder outside this block when the command register or a sized base register may have changed.

Reads are combinational from the address and size inputs. Writes take effect at the rising clock edge while `acc_valid` and `acc_write` are both high.

Top module: `cfgspace_regfile`

## Requirements
- R1: After reset, these bytes hold their parameter values: vendor id at 0x00–0x01, device id at 0x02–0x03, revision at 0x08, 24-bit class code at 0x09–0x0B (low byte first), and header type at 0x0E. The dword of every sized base register holds its type bits. All other bytes read zero. `upd_pulse` and `sec_bus` are 0.
- R2: `acc_size` 00 means 1 byte, 01 means 2 bytes, and 10 or 11 means 4 bytes. Data is little-endian, starting at the offset. A 4-byte read at an offset above 0xFC becomes a 2-byte read. A 2-byte read at an offset above 0xFE becomes a 1-byte read. Unused upper bits read zero.
- R3: An access is present only when bits 23:16 equal OWN_BUS and bits 15:8 equal OWN_DEVFN. Otherwise a read returns 0xFF, 0xFFFF or 0xFFFFFFFF according to the requested width, and a write changes nothing.
- R4: With header type 0x00 or 0x80, byte writes do not change offsets 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x2C–0x33 or 0x3D. Other offsets, such as 0x34 and 0x3C, are writable.
- R5: With any other header type, byte writes do not change offsets 0x00–0x03, 0x08–0x0B, 0x0E, 0x2C–0x2F, 0x38–0x3B or 0x3D. Offsets 0x10–0x27 and 0x30–0x33 are writable.
- R6: A 4-byte write whose offset falls in base register n (0x10+4n, n<6) with a non-zero size S stores (data AND NOT(S-1)) OR type into the aligned dword at 0x10+4n, whatever the offset's low two bits are.
- R7: A 4-byte write at 0x30–0x33 with a non-zero ROM size S stores data AND (NOT(S-1) OR 1) at 0x30. Bit 0, the enable, is kept as written and no type bits are added.
- R8: Bits set in CMD_HI_RSV, STS_LO_RSV and STS_HI_RSV are forced to 0 when bytes 0x05, 0x06 and 0x07 are written.
- R9: A multi-byte write stores byte k of the data at offset+k, one byte at a time, and drops every byte that would land past 0xFF. It never wraps to 0x00.
- R10: When the header type's low 7 bits equal 1 (bridge), a present write at 0x19 of any width, or a 2- or 4-byte write at 0x18, loads `sec_bus` from the data byte that lands at 0x19. A 1-byte write at 0x18 leaves it unchanged.
- R11: A present write that covers offset 0x04 or 0x05, or that takes the base/ROM register path of R6/R7, raises `upd_pulse` for exactly the cycle after the write edge. Other writes and absent writes leave it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | Bus[23:16], device/function[15:8], offset[7:0] |
| acc_size | input | 2 | 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes |
| acc_wdata | input | 32 | Write data, little-endian from the offset |
| rd_data | output | 32 | Read data for the current address and size |
| upd_pulse | output | 1 | One-cycle notice that the mappings may have changed |
| sec_bus | output | 8 | Secondary bus number (bridge header only) |

## Verification
Two instances run side by side. One uses a type-0 header with sized base registers and a ROM window. The other is a bridge with no sized registers, so every write pattern shows both protection maps and each pattern is also an absent-target access for the other instance. All-ones and arbitrary data written to base registers show size masking and type re-insertion apart from plain byte storage. An unaligned dword write shows that the register is selected by its slot. Writes that run off the top of the space, and reads at 0xFD and 0xFF, show byte-by-byte clipping apart from wrapping and show that read widths degrade. Writes that only touch the edge of the command word, at 0x03 and at 0x00, show when the update pulse fires and when it stays low.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

  localparam int BAR_COUNT = 6;
  localparam int BAR_BITS  = 32 * BAR_COUNT;

  typedef struct packed {
    logic        hit;
    logic [7:0]  off;
    logic [2:0]  rlen;
    logic [2:0]  wlen;
    logic        bar_path;
    logic        is_rom;
    logic [31:0] bar_size;
    logic [31:0] bar_type;
  } cfg_dec_t;

  // Requested length in bytes from the size code.
  function automatic logic [2:0] req_len(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Honoured read length after the end-of-space clipping.
  function automatic logic [2:0] read_len(input logic [1:0] sz, input logic [7:0] off);
    logic [2:0] n;
    n = req_len(sz);
    if (n == 3'd4 && off <= 8'hFC) return 3'd4;
    if (n >= 3'd2 && off <= 8'hFE) return 3'd2;
    return 3'd1;
  endfunction

  // Read-only byte map, selected by header type.
  function automatic logic byte_ro(input logic [7:0] off, input logic [7:0] hdr);
    logic common, plain;
    common = (off <= 8'h03) || (off >= 8'h08 && off <= 8'h0B) || (off == 8'h0E) ||
             (off >= 8'h2C && off <= 8'h2F) || (off == 8'h3D);
    plain  = (hdr == 8'h00) || (hdr == 8'h80);
    if (plain) return common || (off >= 8'h10 && off <= 8'h27) || (off >= 8'h30 && off <= 8'h33);
    return common || (off >= 8'h38 && off <= 8'h3B);
  endfunction

  // AND mask applied to a written byte to drop reserved bits.
  function automatic logic [7:0] keep_mask(input logic [7:0] off, input logic [7:0] cmd_hi,
                                           input logic [7:0] sts_lo, input logic [7:0] sts_hi);
    case (off)
      8'h05:   return ~cmd_hi;
      8'h06:   return ~sts_lo;
      8'h07:   return ~sts_hi;
      default: return 8'hFF;
    endcase
  endfunction

  // Size masking for base and ROM register dword writes.
  function automatic logic [31:0] bar_merge(input logic [31:0] val, input logic [31:0] size,
                                            input logic [31:0] typ, input logic is_rom);
    logic [31:0] keep;
    keep = ~(size - 32'd1);
    if (is_rom) return val & (keep | 32'd1);
    return (val & keep) | typ;
  endfunction

endpackage

// File: rtl/cfgspace_decode.sv
module cfgspace_decode
  import cfgspace_pkg::*;
#(
  parameter logic [7:0]          OWN_BUS   = 8'h00,
  parameter logic [7:0]          OWN_DEVFN = 8'h18,
  parameter logic [BAR_BITS-1:0] BAR_SIZES = '0,
  parameter logic [BAR_BITS-1:0] BAR_TYPES = '0,
  parameter logic [31:0]         ROM_SIZE  = 32'h0
) (
  input  logic [23:0] addr,
  input  logic [1:0]  size,
  output cfg_dec_t    dec
);

  logic [5:0] slot;
  logic       in_bar, in_rom;

  always_comb begin
    dec      = '0;
    dec.hit  = (addr[23:16] == OWN_BUS) && (addr[15:8] == OWN_DEVFN);
    dec.off  = addr[7:0];
    dec.rlen = read_len(size, addr[7:0]);
    dec.wlen = req_len(size);
    slot     = addr[7:2] - 6'd4;
    in_bar   = (addr[7:2] >= 6'd4) && (slot < 6'(BAR_COUNT));
    in_rom   = (addr[7:2] == 6'd12);
    for (int i = 0; i < BAR_COUNT; i++) begin
      if (in_bar && slot == 6'(i)) begin
        dec.bar_size = BAR_SIZES[i*32 +: 32];
        dec.bar_type = BAR_TYPES[i*32 +: 32];
      end
    end
    if (in_rom) begin
      dec.bar_size = ROM_SIZE;
      dec.is_rom   = 1'b1;
    end
    dec.bar_path = (dec.wlen == 3'd4) && (in_bar || in_rom) && (dec.bar_size != 32'd0);
  end

endmodule

// File: rtl/cfgspace_wlanes.sv
module cfgspace_wlanes
  import cfgspace_pkg::*;
#(
  parameter logic [7:0] HDR        = 8'h00,
  parameter logic [7:0] CMD_HI_RSV = 8'hF8,
  parameter logic [7:0] STS_LO_RSV = 8'h07,
  parameter logic [7:0] STS_HI_RSV = 8'h06
) (
  input  logic            wr_go,
  input  logic [7:0]      off,
  input  logic [2:0]      wlen,
  input  logic            bar_path,
  input  logic            is_rom,
  input  logic [31:0]     bar_size,
  input  logic [31:0]     bar_type,
  input  logic [31:0]     wdata,
  output logic [3:0]      lane_we,
  output logic [3:0][7:0] lane_off,
  output logic [3:0][7:0] lane_data
);

  logic [31:0] merged;
  logic [8:0]  pos;

  assign merged = bar_merge(wdata, bar_size, bar_type, is_rom);

  always_comb begin
    lane_we   = '0;
    lane_off  = '0;
    lane_data = '0;
    pos       = '0;
    for (int k = 0; k < 4; k++) begin
      if (bar_path) begin
        lane_off[k]  = {off[7:2], 2'(k)};
        lane_data[k] = merged[8*k +: 8];
        lane_we[k]   = wr_go;
      end else begin
        pos          = {1'b0, off} + 9'(k);
        lane_off[k]  = pos[7:0];
        lane_data[k] = wdata[8*k +: 8] & keep_mask(pos[7:0], CMD_HI_RSV, STS_LO_RSV, STS_HI_RSV);
        lane_we[k]   = wr_go && (3'(k) < wlen) && !pos[8] && !byte_ro(pos[7:0], HDR);
      end
    end
  end

endmodule

// File: rtl/cfgspace_rmux.sv
module cfgspace_rmux
  import cfgspace_pkg::*;
(
  input  logic            hit,
  input  logic [1:0]      size,
  input  logic [2:0]      rlen,
  input  logic [3:0][7:0] bytes,
  output logic [31:0]     rd_data
);

  always_comb begin
    if (!hit) begin
      case (req_len(size))
        3'd1:    rd_data = 32'h0000_00FF;
        3'd2:    rd_data = 32'h0000_FFFF;
        default: rd_data = 32'hFFFF_FFFF;
      endcase
    end else begin
      case (rlen)
        3'd4:    rd_data = bytes;
        3'd2:    rd_data = {16'h0, bytes[1], bytes[0]};
        default: rd_data = {24'h0, bytes[0]};
      endcase
    end
  end

endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
  import cfgspace_pkg::*;
#(
  parameter logic [7:0]          OWN_BUS    = 8'h00,
  parameter logic [7:0]          OWN_DEVFN  = 8'h18,
  parameter logic [15:0]         VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0]         DEVICE_ID  = 16'h5A17,
  parameter logic [7:0]          REVISION   = 8'h03,
  parameter logic [23:0]         CLASS_CODE = 24'h020000,
  parameter logic [7:0]          HDR        = 8'h00,
  parameter logic [BAR_BITS-1:0] BAR_SIZES  = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_0100},
  parameter logic [BAR_BITS-1:0] BAR_TYPES  = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0001},
  parameter logic [31:0]         ROM_SIZE   = 32'h0000_0800,
  parameter logic [7:0]          CMD_HI_RSV = 8'hF8,
  parameter logic [7:0]          STS_LO_RSV = 8'h07,
  parameter logic [7:0]          STS_HI_RSV = 8'h06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [23:0] acc_addr,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic [31:0] rd_data,
  output logic        upd_pulse,
  output logic [7:0]  sec_bus
);

  localparam int  SPACE     = 256;
  localparam logic IS_BRIDGE = (HDR[6:0] == 7'h01);

  logic [7:0]      cfg_mem [SPACE];
  cfg_dec_t        dec;
  logic            wr_go, tgt_hit, cmd_touch, bus_touch;
  logic [3:0]      lane_we;
  logic [3:0][7:0] lane_off, lane_data, rd_bytes;

  function automatic logic [7:0] init_byte(input logic [7:0] o);
    logic [7:0] v;
    v = 8'h00;
    case (o)
      8'h00: v = VENDOR_ID[7:0];
      8'h01: v = VENDOR_ID[15:8];
      8'h02: v = DEVICE_ID[7:0];
      8'h03: v = DEVICE_ID[15:8];
      8'h08: v = REVISION;
      8'h09: v = CLASS_CODE[7:0];
      8'h0A: v = CLASS_CODE[15:8];
      8'h0B: v = CLASS_CODE[23:16];
      8'h0E: v = HDR;
      default: begin
        for (int b = 0; b < BAR_COUNT; b++) begin
          if (o[7:2] == 6'(b + 4) && BAR_SIZES[b*32 +: 32] != 32'd0)
            v = BAR_TYPES[b*32 + 8*o[1:0] +: 8];
        end
      end
    endcase
    return v;
  endfunction

  cfgspace_decode #(
    .OWN_BUS(OWN_BUS), .OWN_DEVFN(OWN_DEVFN),
    .BAR_SIZES(BAR_SIZES), .BAR_TYPES(BAR_TYPES), .ROM_SIZE(ROM_SIZE)
  ) u_decode (
    .addr(acc_addr), .size(acc_size), .dec(dec)
  );

  assign tgt_hit = dec.hit;
  assign wr_go   = acc_valid && acc_write && dec.hit;

  cfgspace_wlanes #(
    .HDR(HDR), .CMD_HI_RSV(CMD_HI_RSV), .STS_LO_RSV(STS_LO_RSV), .STS_HI_RSV(STS_HI_RSV)
  ) u_wlanes (
    .wr_go(wr_go), .off(dec.off), .wlen(dec.wlen), .bar_path(dec.bar_path),
    .is_rom(dec.is_rom), .bar_size(dec.bar_size), .bar_type(dec.bar_type),
    .wdata(acc_wdata), .lane_we(lane_we), .lane_off(lane_off), .lane_data(lane_data)
  );

  always_comb begin
    for (int k = 0; k < 4; k++) rd_bytes[k] = cfg_mem[dec.off + 8'(k)];
  end

  cfgspace_rmux u_rmux (
    .hit(dec.hit), .size(acc_size), .rlen(dec.rlen), .bytes(rd_bytes), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPACE; i++) cfg_mem[i] <= init_byte(8'(i));
    end else begin
      for (int k = 0; k < 4; k++)
        if (lane_we[k]) cfg_mem[lane_off[k]] <= lane_data[k];
    end
  end

  // Command word is 0x04..0x05; the write covers it if it starts at or below 5 and ends past 4.
  assign cmd_touch = (dec.off <= 8'h05) && (({1'b0, dec.off} + 9'(dec.wlen)) > 9'h004);
  assign bus_touch = IS_BRIDGE && ((dec.off == 8'h19) || (dec.off == 8'h18 && dec.wlen > 3'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_pulse <= 1'b0;
      sec_bus   <= 8'h00;
    end else begin
      upd_pulse <= wr_go && (cmd_touch || dec.bar_path);
      if (wr_go && bus_touch)
        sec_bus <= (dec.off == 8'h19) ? acc_wdata[7:0] : acc_wdata[15:8];
    end
  end

endmodule

// File: rtl/cfgspace_checker.sv
module cfgspace_checker #(
  parameter logic [7:0] HDR = 8'h00
) (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] acc_addr,
  input logic [1:0]  acc_size,
  input logic [31:0] rd_data,
  input logic        upd_pulse,
  input logic [7:0]  sec_bus,
  input logic        wr_go,
  input logic        tgt_hit
);

  a_r11_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> $past(wr_go));

  a_r10_secbus_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_bus) |-> $past(wr_go));

  a_r3_absent_word_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_hit && acc_size[1]) |-> (rd_data == 32'hFFFF_FFFF));

  a_r2_byte_read_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b00) |-> (rd_data[31:8] == 24'h0));

  a_r1_header_byte_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_hit && acc_addr[7:0] == 8'h0E && acc_size == 2'b00) |-> (rd_data[7:0] == HDR));

endmodule

bind cfgspace_regfile cfgspace_checker #(.HDR(HDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
  .rd_data(rd_data), .upd_pulse(upd_pulse), .sec_bus(sec_bus),
  .wr_go(wr_go), .tgt_hit(tgt_hit)
);

// File: tb/cfgspace_regfile_tb.sv
module cfgspace_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_main, rd_br;
  logic        pulse_main, pulse_br;
  logic [7:0]  sec_main, sec_br;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cfgspace_regfile #(.HDR(8'h80)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_data(rd_main), .upd_pulse(pulse_main), .sec_bus(sec_main)
  );

  cfgspace_regfile #(
    .OWN_DEVFN(8'h08), .HDR(8'h01), .CLASS_CODE(24'h060400),
    .BAR_SIZES('0), .BAR_TYPES('0), .ROM_SIZE(32'h0)
  ) u_dut_br (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_data(rd_br), .upd_pulse(pulse_br), .sec_bus(sec_br)
  );

  function automatic logic [23:0] am(input logic [7:0] off); return {8'h00, 8'h18, off}; endfunction
  function automatic logic [23:0] ab(input logic [7:0] off); return {8'h00, 8'h08, off}; endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [1:0] s);
    @(negedge clk);
    acc_addr = a; acc_size = s;
    #1;
  endtask

  task automatic t_reset;
    rd(am(8'h00), 2'b10); chk("R1 main id", rd_main, 32'h5A17_C0DE);
    rd(am(8'h08), 2'b10); chk("R1 main class/rev", rd_main, 32'h0200_0003);
    rd(am(8'h0C), 2'b10); chk("R1 main header", rd_main, 32'h0080_0000);
    rd(am(8'h10), 2'b10); chk("R1 bar0 type", rd_main, 32'h0000_0001);
    rd(am(8'h14), 2'b10); chk("R1 bar1 type", rd_main, 32'h0000_0008);
    rd(am(8'h3C), 2'b10); chk("R1 cleared byte", rd_main, 32'h0);
    rd(ab(8'h0C), 2'b10); chk("R1 bridge header", rd_br, 32'h0001_0000);
    chk("R1 pulse idle", {31'h0, pulse_main}, 32'h0);
    chk("R1 sec bus", {24'h0, sec_br}, 32'h0);
  endtask

  task automatic t_widths;
    rd(am(8'h02), 2'b01); chk("R2 half read", rd_main, 32'h0000_5A17);
    rd(am(8'h01), 2'b00); chk("R2 byte read", rd_main, 32'h0000_00C0);
    rd(am(8'h00), 2'b11); chk("R2 size 11 is word", rd_main, 32'h5A17_C0DE);
  endtask

  task automatic t_ro_plain;
    wr(am(8'h00), 2'b10, 32'hFFFF_FFFF); rd(am(8'h00), 2'b10); chk("R4 id locked", rd_main, 32'h5A17_C0DE);
    wr(am(8'h08), 2'b10, 32'hFFFF_FFFF); rd(am(8'h08), 2'b10); chk("R4 class locked", rd_main, 32'h0200_0003);
    wr(am(8'h0E), 2'b00, 32'h0000_0055); rd(am(8'h0E), 2'b00); chk("R4 header locked", rd_main, 32'h0000_0080);
    wr(am(8'h10), 2'b00, 32'h0000_00AB); rd(am(8'h10), 2'b10); chk("R4 bar byte write", rd_main, 32'h0000_0001);
    wr(am(8'h18), 2'b10, 32'hFFFF_FFFF); rd(am(8'h18), 2'b10); chk("R4 unsized bar", rd_main, 32'h0);
    wr(am(8'h2C), 2'b10, 32'hFFFF_FFFF); rd(am(8'h2C), 2'b10); chk("R4 subsystem", rd_main, 32'h0);
    wr(am(8'h3C), 2'b01, 32'h0000_BBAA); rd(am(8'h3C), 2'b10); chk("R4 3C rw 3D ro", rd_main, 32'h0000_00AA);
    wr(am(8'h34), 2'b00, 32'h0000_005C); rd(am(8'h34), 2'b00); chk("R4 34 writable", rd_main, 32'h0000_005C);
  endtask

  task automatic t_reserved;
    wr(am(8'h04), 2'b01, 32'h0000_FFFF); rd(am(8'h04), 2'b01); chk("R8 command", rd_main, 32'h0000_07FF);
    wr(am(8'h04), 2'b10, 32'hFFFF_FFFF); rd(am(8'h04), 2'b10); chk("R8 status", rd_main, 32'hF9F8_07FF);
  endtask

  task automatic t_bars;
    wr(am(8'h10), 2'b10, 32'hFFFF_FFFF); rd(am(8'h10), 2'b10); chk("R6 bar0 size probe", rd_main, 32'hFFFF_FF01);
    wr(am(8'h14), 2'b10, 32'h1234_5678); rd(am(8'h14), 2'b10); chk("R6 bar1 mask+type", rd_main, 32'h1234_5008);
    wr(am(8'h11), 2'b10, 32'h0000_AB00); rd(am(8'h10), 2'b10); chk("R6 unaligned slot", rd_main, 32'h0000_AB01);
    wr(am(8'h30), 2'b10, 32'hABCD_E7F1); rd(am(8'h30), 2'b10); chk("R7 rom enable kept", rd_main, 32'hABCD_E001);
    wr(am(8'h30), 2'b10, 32'hFFFF_F800); rd(am(8'h30), 2'b10); chk("R7 rom disabled", rd_main, 32'hFFFF_F800);
  endtask

  task automatic t_tail;
    wr(am(8'hFE), 2'b10, 32'h4433_2211);
    rd(am(8'hFE), 2'b01); chk("R9 tail bytes", rd_main, 32'h0000_2211);
    rd(am(8'h00), 2'b10); chk("R9 no wrap", rd_main, 32'h5A17_C0DE);
    rd(am(8'hFD), 2'b10); chk("R2 word at FD degrades", rd_main, 32'h0000_1100);
    rd(am(8'hFF), 2'b10); chk("R2 word at FF degrades", rd_main, 32'h0000_0022);
  endtask

  task automatic t_absent;
    rd({8'h01, 8'h18, 8'h00}, 2'b00); chk("R3 absent byte", rd_main, 32'h0000_00FF);
    rd({8'h00, 8'h19, 8'h00}, 2'b01); chk("R3 absent half", rd_main, 32'h0000_FFFF);
    rd({8'h00, 8'h20, 8'h00}, 2'b10); chk("R3 absent word", rd_main, 32'hFFFF_FFFF);
    wr({8'h01, 8'h18, 8'h3C}, 2'b00, 32'h0000_0077);
    chk("R3 absent no pulse", {31'h0, pulse_main}, 32'h0);
    rd(am(8'h3C), 2'b00); chk("R3 absent write dropped", rd_main, 32'h0000_00AA);
  endtask

  task automatic t_pulse;
    wr(am(8'h04), 2'b00, 32'h0000_0006); chk("R11 command write pulse", {31'h0, pulse_main}, 32'h1);
    @(negedge clk); chk("R11 pulse one cycle", {31'h0, pulse_main}, 32'h0);
    wr(am(8'h3C), 2'b00, 32'h0000_0011); chk("R11 no pulse elsewhere", {31'h0, pulse_main}, 32'h0);
    wr(am(8'h03), 2'b01, 32'h0000_0600); chk("R11 edge 03 half", {31'h0, pulse_main}, 32'h1);
    wr(am(8'h00), 2'b10, 32'h0000_0000); chk("R11 word at 00", {31'h0, pulse_main}, 32'h0);
    wr(am(8'h14), 2'b10, 32'h0000_0000); chk("R11 bar write pulse", {31'h0, pulse_main}, 32'h1);
  endtask

  task automatic t_bridge;
    wr(ab(8'h10), 2'b10, 32'hDEAD_BEEF); rd(ab(8'h10), 2'b10); chk("R5 bridge 10 rw", rd_br, 32'hDEAD_BEEF);
    chk("R5 bridge bar no pulse", {31'h0, pulse_br}, 32'h0);
    rd(am(8'h10), 2'b10); chk("R3 other target untouched", rd_main, 32'h0000_AB01);
    wr(ab(8'h30), 2'b10, 32'h1234_5678); rd(ab(8'h30), 2'b10); chk("R5 bridge 30 rw", rd_br, 32'h1234_5678);
    wr(ab(8'h38), 2'b10, 32'hFFFF_FFFF); rd(ab(8'h38), 2'b10); chk("R5 bridge 38 ro", rd_br, 32'h0);
    wr(ab(8'h2C), 2'b10, 32'hFFFF_FFFF); rd(ab(8'h2C), 2'b10); chk("R5 bridge 2C ro", rd_br, 32'h0);
    wr(ab(8'h19), 2'b00, 32'h0000_0005); chk("R10 byte at 19", {24'h0, sec_br}, 32'h05);
    wr(ab(8'h18), 2'b10, 32'h0000_2A01); chk("R10 word at 18", {24'h0, sec_br}, 32'h2A);
    rd(ab(8'h18), 2'b10); chk("R10 stored too", rd_br, 32'h0000_2A01);
    wr(ab(8'h18), 2'b00, 32'h0000_0099); chk("R10 byte at 18 ignored", {24'h0, sec_br}, 32'h2A);
    wr(ab(8'h19), 2'b01, 32'h0000_0033); chk("R10 half at 19", {24'h0, sec_br}, 32'h33);
    chk("R10 plain header no bus", {24'h0, sec_main}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_widths;
    t_ro_plain;
    t_reserved;
    t_bars;
    t_tail;
    t_absent;
    t_pulse;
    t_bridge;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule